// File: doc/BRIEF.md
# Nibble-Coded 16-Bit Register Machine

This block is a compact 16-bit processor core for a byte-coded interpreter instruction set. It holds sixteen 16-bit registers. Register 0 acts as the accumulator, register 15 is the program counter, and one register (register 12 by default) serves as the stack pointer for subroutine linkage. Each opcode byte has two halves. The upper nibble picks an operation and the lower nibble picks a register. An upper nibble of zero instead selects one of thirteen control operations: return to host, break, subroutine return, and relative branches.

The core reaches memory through a single byte-wide port. It raises a request and holds address, direction and write data until the memory acknowledges. Read data is taken in the acknowledging cycle. Branches look at the register written by the most recent register operation, and at a carry bit that add, subtract and compare leave behind. Return-to-host and break each give a one-cycle pulse, after which the core stops issuing requests until reset.

Top module: `nib16_core`

## Requirements
- R1: While reset is asserted and immediately after it, the core requests a read (`mem_we`=0) at address `RESET_PC`, and `host_ret` and `brk` are low. All registers other than the program counter reset to zero.
- R2: Once `mem_req` is high without `mem_ack`, the address, direction and write data stay unchanged in the next cycle. Exactly one byte moves per acknowledged cycle.
- R3: Register opcodes are coded as follows: 0x1n loads Rn with the next two bytes, low first. 0x2n copies Rn into R0 and 0x3n copies R0 into Rn. 0xEn adds one to Rn and 0xFn subtracts one from Rn.
- R4: 0x4n reads the byte at address Rn into R0 (upper byte cleared) and 0x5n writes R0's low byte to address Rn. Both then add one to Rn. 0x8n and 0x9n first subtract one from Rn and then read into R0 or write R0's low byte at the new Rn.
- R5: 0x6n reads two bytes at Rn (low) and Rn+1 (high) into R0, and 0x7n writes R0 low then high to those two addresses. Both add two to Rn. 0xCn subtracts two from Rn and reads R0 from the new Rn (low) and Rn+1 (high).
- R6: 0xAn sets R0 to R0+Rn and 0xBn sets R0 to R0−Rn. 0xDn writes R0−Rn to register `CMP_IDX` (13) and leaves R0 alone. All three set carry to the add carry-out, or to "no borrow" (R0 ≥ Rn unsigned) for subtract and compare.
- R7: The result register is R0 for 0x2n, 0x4n, 0x6n, 0x8n, 0xAn, 0xBn and 0xCn. It is Rn for 0x1n, 0x3n, 0x5n, 0x7n, 0x9n, 0xEn and 0xFn, and `CMP_IDX` for 0xDn. The branch codes test this register and the carry bit: 01 always, 02 carry clear, 03 carry set, 04 bit 15 clear, 05 bit 15 set, 06 zero, 07 non-zero, 08 equal to 0xFFFF, 09 not 0xFFFF.
- R8: A branch is followed by a signed 8-bit displacement byte. A taken branch goes to the address after that byte plus the displacement, and backward displacements loop correctly. A branch not taken continues after that byte.
- R9: 0x0C writes the return address (the address after its displacement byte) low byte to address SP and high byte to address SP+1. It then adds two to SP and branches unconditionally. 0x0B reads the high byte from SP−1 and the low byte from SP−2, subtracts two from SP and resumes at that address.
- R10: 0x00 pulses `host_ret` for one cycle and 0x0A pulses `brk` for one cycle. The two never pulse together, and after either one no further memory request is made until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the acknowledging cycle |
| mem_ack | input | 1 | Access completes this cycle |
| host_ret | output | 1 | One-cycle pulse on return-to-host |
| brk | output | 1 | One-cycle pulse on break |

## Verification
The assertions assume that memory raises `mem_ack` only while `mem_req` is high and presents read data in that same cycle. The bench memory model builds acknowledge as request ANDed with a ready bit that is randomised at each falling edge, so waits of any length occur and no acknowledge arrives without a request. The assertions also assume that programs avoid the undefined codes 0x0D–0x0F and never use the pointer register as R0. The bench programs are generated from templates that follow both rules, with only the operands, the arithmetic operation and the branch code chosen at random.

// File: rtl/nib16_pkg.sv
package nib16_pkg;
   localparam int XW  = 16;
   localparam int NR  = 16;
   localparam int IW  = $clog2(NR);
   localparam int PCI = NR - 1;

   typedef enum logic [3:0] {
      G_CTL  = 4'h0, G_SET  = 4'h1, G_LD   = 4'h2, G_ST   = 4'h3,
      G_LDI  = 4'h4, G_STI  = 4'h5, G_LDDI = 4'h6, G_STDI = 4'h7,
      G_POP  = 4'h8, G_STP  = 4'h9, G_ADD  = 4'hA, G_SUB  = 4'hB,
      G_POPD = 4'hC, G_CPR  = 4'hD, G_INR  = 4'hE, G_DCR  = 4'hF
   } opgrp_e;

   localparam logic [3:0] C_RTN = 4'h0;
   localparam logic [3:0] C_BK  = 4'hA;
   localparam logic [3:0] C_RS  = 4'hB;
   localparam logic [3:0] C_BS  = 4'hC;

   typedef enum logic [2:0] {
      ST_FETCH, ST_EXEC, ST_MEM, ST_FIN, ST_HALT
   } state_e;
endpackage

// File: rtl/nib16_regfile.sv
module nib16_regfile #(
   parameter int             N      = 16,
   parameter int             W      = 16,
   parameter int             PC_IDX = 15,
   parameter logic [W-1:0]   PC_RST = '0,
   localparam int            AW     = $clog2(N)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                a_we,
   input  logic [AW-1:0]       a_idx,
   input  logic [W-1:0]        a_data,
   input  logic                b_we,
   input  logic [AW-1:0]       b_idx,
   input  logic [W-1:0]        b_data,
   output logic [N-1:0][W-1:0] regs_o
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_reg
         localparam logic [W-1:0] RV = (i == PC_IDX) ? PC_RST : '0;
         always_ff @(posedge clk) begin
            if (!rst_n)
               regs_o[i] <= RV;
            else if (b_we && b_idx == AW'(i))
               regs_o[i] <= b_data;
            else if (a_we && a_idx == AW'(i))
               regs_o[i] <= a_data;
         end
      end
   endgenerate
endmodule

// File: rtl/nib16_alu.sv
module nib16_alu #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y,
   output logic         cout
);
   logic [W:0] sum;
   always_comb begin
      sum  = {1'b0, a} + {1'b0, (sub ? ~b : b)} + {{W{1'b0}}, sub};
      y    = sum[W-1:0];
      cout = sum[W];
   end
endmodule

// File: rtl/nib16_cond.sv
module nib16_cond #(
   parameter int W = 16
) (
   input  logic [3:0]   code,
   input  logic [W-1:0] val,
   input  logic         carry,
   output logic         take
);
   logic zero, ones, neg;
   always_comb begin
      zero = (val == '0);
      ones = (val == '1);
      neg  = val[W-1];
      unique case (code)
         4'h1, 4'hC: take = 1'b1;
         4'h2:       take = !carry;
         4'h3:       take = carry;
         4'h4:       take = !neg;
         4'h5:       take = neg;
         4'h6:       take = zero;
         4'h7:       take = !zero;
         4'h8:       take = ones;
         4'h9:       take = !ones;
         default:    take = 1'b0;
      endcase
   end
endmodule

// File: rtl/nib16_core.sv
module nib16_core
   import nib16_pkg::*;
#(
   parameter logic [15:0] RESET_PC = 16'h0000,
   parameter int          SP_IDX   = 12,
   parameter int          CMP_IDX  = 13
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic        mem_req,
   output logic        mem_we,
   output logic [15:0] mem_addr,
   output logic [7:0]  mem_wdata,
   input  logic [7:0]  mem_rdata,
   input  logic        mem_ack,
   output logic        host_ret,
   output logic        brk
);
   generate
      if (SP_IDX < 1 || SP_IDX >= PCI) begin : g_bad_sp
         $error("SP_IDX must name a general register other than R0 and the PC");
      end
      if (CMP_IDX < 1 || CMP_IDX >= PCI) begin : g_bad_cmp
         $error("CMP_IDX must name a general register other than R0 and the PC");
      end
   endgenerate

   localparam logic [IW-1:0] SPI = IW'(SP_IDX);
   localparam logic [IW-1:0] CPI = IW'(CMP_IDX);
   localparam logic [IW-1:0] PCX = IW'(PCI);

   state_e           st;
   logic [7:0]       ir;
   logic [XW-1:0]    ma, tmp, wsrc;
   logic             bc, two, desc, wr, push_ph, carry;
   logic [IW-1:0]    res_idx;

   logic [NR-1:0][XW-1:0] regs;
   logic             a_we, b_we;
   logic [IW-1:0]    a_idx, b_idx;
   logic [XW-1:0]    a_data, b_data;

   opgrp_e           grp;
   logic [IW-1:0]    rn;
   logic [XW-1:0]    pc, r0, rnv, sp, target;
   logic [XW-1:0]    alu_y;
   logic             alu_c, take, sel_hi, last_byte;

   assign grp    = opgrp_e'(ir[7:4]);
   assign rn     = ir[3:0];
   assign pc     = regs[PCI];
   assign r0     = regs[0];
   assign rnv    = regs[rn];
   assign sp     = regs[SP_IDX];
   assign target = pc + 16'd1 + {{8{tmp[7]}}, tmp[7:0]};
   assign sel_hi = two & (desc ? ~bc : bc);
   assign last_byte = !two || bc;

   nib16_regfile #(.N(NR), .W(XW), .PC_IDX(PCI), .PC_RST(RESET_PC)) i_rf (
      .clk(clk), .rst_n(rst_n),
      .a_we(a_we), .a_idx(a_idx), .a_data(a_data),
      .b_we(b_we), .b_idx(b_idx), .b_data(b_data),
      .regs_o(regs)
   );

   nib16_alu #(.W(XW)) i_alu (
      .a(r0), .b(rnv), .sub(grp != G_ADD), .y(alu_y), .cout(alu_c)
   );

   nib16_cond #(.W(XW)) i_cond (
      .code(ir[3:0]), .val(regs[res_idx]), .carry(carry), .take(take)
   );

   // memory port
   always_comb begin
      mem_req   = (st == ST_FETCH) || (st == ST_MEM);
      mem_we    = (st == ST_MEM) && wr;
      mem_addr  = (st == ST_FETCH) ? pc : ma;
      mem_wdata = sel_hi ? wsrc[15:8] : wsrc[7:0];
      host_ret  = (st == ST_EXEC) && (ir == 8'h00);
      brk       = (st == ST_EXEC) && (ir == {4'h0, C_BK});
   end

   // register file writes: port b wins over port a on the same index
   always_comb begin
      a_we = 1'b0; a_idx = '0; a_data = '0;
      b_we = 1'b0; b_idx = '0; b_data = '0;
      unique case (st)
         ST_FETCH: begin
            a_we = mem_ack; a_idx = PCX; a_data = pc + 16'd1;
         end
         ST_EXEC: begin
            unique case (grp)
               G_LD:  begin b_we = 1'b1; b_idx = '0;  b_data = rnv;          end
               G_ST:  begin b_we = 1'b1; b_idx = rn;  b_data = r0;           end
               G_ADD, G_SUB:
                      begin b_we = 1'b1; b_idx = '0;  b_data = alu_y;        end
               G_CPR: begin b_we = 1'b1; b_idx = CPI; b_data = alu_y;        end
               G_INR: begin b_we = 1'b1; b_idx = rn;  b_data = rnv + 16'd1;  end
               G_DCR: begin b_we = 1'b1; b_idx = rn;  b_data = rnv - 16'd1;  end
               default: ;
            endcase
         end
         ST_FIN: begin
            unique case (grp)
               G_SET: begin
                  a_we = 1'b1; a_idx = PCX; a_data = pc + 16'd2;
                  b_we = 1'b1; b_idx = rn;  b_data = tmp;
               end
               G_LDI, G_LDDI, G_POP, G_POPD: begin
                  a_we = 1'b1; a_idx = rn;
                  a_data = (grp == G_LDI)  ? rnv + 16'd1 :
                           (grp == G_LDDI) ? rnv + 16'd2 :
                           (grp == G_POP)  ? rnv - 16'd1 : rnv - 16'd2;
                  b_we = 1'b1; b_idx = '0;
                  b_data = two ? tmp : {8'h00, tmp[7:0]};
               end
               G_STI:  begin a_we = 1'b1; a_idx = rn; a_data = rnv + 16'd1; end
               G_STDI: begin a_we = 1'b1; a_idx = rn; a_data = rnv + 16'd2; end
               G_STP:  begin a_we = 1'b1; a_idx = rn; a_data = rnv - 16'd1; end
               G_CTL: begin
                  if (ir[3:0] == C_RS) begin
                     a_we = 1'b1; a_idx = SPI; a_data = sp - 16'd2;
                     b_we = 1'b1; b_idx = PCX; b_data = tmp;
                  end else if (ir[3:0] == C_BS && push_ph) begin
                     a_we = 1'b1; a_idx = SPI; a_data = sp + 16'd2;
                  end else begin
                     a_we = 1'b1; a_idx = PCX;
                     a_data = take ? target : pc + 16'd1;
                  end
               end
               default: ;
            endcase
         end
         default: ;
      endcase
   end

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_FETCH; ir <= '0; ma <= '0; tmp <= '0; wsrc <= '0;
         bc <= 1'b0; two <= 1'b0; desc <= 1'b0; wr <= 1'b0;
         push_ph <= 1'b0; carry <= 1'b0; res_idx <= '0;
      end else begin
         unique case (st)
            ST_FETCH: if (mem_ack) begin
               ir <= mem_rdata;
               st <= ST_EXEC;
            end
            ST_EXEC: begin
               bc <= 1'b0;
               st <= ST_FETCH;
               unique case (grp)
                  G_CTL: begin
                     if (ir[3:0] == C_RTN || ir[3:0] == C_BK) begin
                        st <= ST_HALT;
                     end else if (ir[3:0] == C_RS) begin
                        ma <= sp - 16'd1; two <= 1'b1; desc <= 1'b1; wr <= 1'b0;
                        st <= ST_MEM;
                     end else if (ir[3:0] <= C_BS) begin
                        ma <= pc; two <= 1'b0; desc <= 1'b0; wr <= 1'b0;
                        push_ph <= 1'b0;
                        st <= ST_MEM;
                     end
                  end
                  G_SET: begin
                     ma <= pc; two <= 1'b1; desc <= 1'b0; wr <= 1'b0;
                     res_idx <= rn; st <= ST_MEM;
                  end
                  G_LD:  res_idx <= '0;
                  G_ST, G_INR, G_DCR: res_idx <= rn;
                  G_ADD, G_SUB: begin res_idx <= '0; carry <= alu_c; end
                  G_CPR: begin res_idx <= CPI; carry <= alu_c; end
                  G_LDI, G_LDDI: begin
                     ma <= rnv; two <= (grp == G_LDDI); desc <= 1'b0; wr <= 1'b0;
                     res_idx <= '0; st <= ST_MEM;
                  end
                  G_POP, G_POPD: begin
                     ma <= rnv - 16'd1; two <= (grp == G_POPD); desc <= 1'b1;
                     wr <= 1'b0; res_idx <= '0; st <= ST_MEM;
                  end
                  G_STI, G_STDI: begin
                     ma <= rnv; wsrc <= r0; two <= (grp == G_STDI); desc <= 1'b0;
                     wr <= 1'b1; res_idx <= rn; st <= ST_MEM;
                  end
                  G_STP: begin
                     ma <= rnv - 16'd1; wsrc <= r0; two <= 1'b0; desc <= 1'b1;
                     wr <= 1'b1; res_idx <= rn; st <= ST_MEM;
                  end
                  default: ;
               endcase
            end
            ST_MEM: if (mem_ack) begin
               if (!wr) begin
                  if (sel_hi) tmp[15:8] <= mem_rdata;
                  else        tmp[7:0]  <= mem_rdata;
               end
               ma <= desc ? ma - 16'd1 : ma + 16'd1;
               if (last_byte) st <= ST_FIN;
               else           bc <= 1'b1;
            end
            ST_FIN: begin
               st <= ST_FETCH;
               if (grp == G_CTL && ir[3:0] == C_BS && !push_ph) begin
                  push_ph <= 1'b1;
                  wsrc <= pc + 16'd1;
                  ma <= sp; two <= 1'b1; desc <= 1'b0; wr <= 1'b1; bc <= 1'b0;
                  st <= ST_MEM;
               end
            end
            default: st <= ST_HALT;
         endcase
      end
   end

   // checks
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata)));

   assert_fetch_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FETCH && mem_ack) |=> (pc == $past(pc) + 16'd1));

   assert_ret_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      host_ret |=> (!host_ret && !mem_req));

   assert_brk_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      brk |=> (!brk && !mem_req));

   assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_ret && brk));

   assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HALT) |=> (st == ST_HALT && !mem_req));
endmodule

// File: tb/test_nib16_core.sv
module test_nib16_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_req, mem_we, mem_ack, host_ret, brk;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        rdy = 1'b1;
   logic [7:0]  mem [0:2047];

   int checks = 0;
   int errors = 0;
   int ret_n = 0;
   int brk_n = 0;
   int req_after = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   nib16_core i_nib16_core (
      .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack), .host_ret(host_ret), .brk(brk)
   );

   assign mem_ack   = mem_req & rdy;
   assign mem_rdata = mem[mem_addr[10:0]];

   always @(posedge clk) begin
      if (rst_n && mem_req && mem_we && mem_ack) mem[mem_addr[10:0]] <= mem_wdata;
      if (rst_n && host_ret) ret_n <= ret_n + 1;
      if (rst_n && brk) brk_n <= brk_n + 1;
      if (rst_n && done && mem_req) req_after <= req_after + 1;
   end

   initial begin
      forever begin
         @(negedge clk);
         rdy = ($urandom % 4) != 0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put(input int a, input logic [7:0] b);
      mem[a] = b;
   endtask

   task automatic begin_prog();
      rst_n = 1'b0;
      done = 1'b0;
      for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
   endtask

   task automatic run_prog();
      int cyc;
      @(negedge clk); @(negedge clk);
      ret_n = 0; brk_n = 0; req_after = 0;
      rst_n = 1'b1;
      cyc = 0;
      while (ret_n == 0 && brk_n == 0 && cyc < 4000) begin
         @(negedge clk);
         cyc++;
      end
      if (cyc >= 4000) begin
         errors++; checks++;
         $display("FAIL watchdog: program did not end, actual %0d expected <4000", cyc);
      end
      @(negedge clk);
      done = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   function automatic bit br_take(input logic [3:0] code, input logic [15:0] v, input bit c);
      case (code)
         4'h1: return 1'b1;
         4'h2: return !c;
         4'h3: return c;
         4'h4: return !v[15];
         4'h5: return v[15];
         4'h6: return v == 16'h0000;
         4'h7: return v != 16'h0000;
         4'h8: return v == 16'hFFFF;
         4'h9: return v != 16'hFFFF;
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state
      begin_prog();
      repeat (3) @(negedge clk);
      chk("R1 req", mem_req, 1);
      chk("R1 we", mem_we, 0);
      chk("R1 addr", mem_addr, 16'h0000);
      chk("R1 ret/brk", {host_ret, brk}, 0);

      // R2 R4 R5: indirect, pop, double-byte
      begin_prog();
      put(16'h300, 8'h5A); put(16'h301, 8'hC3);
      put(0, 8'h15); put(1, 8'h00); put(2, 8'h03);   // SET R5 0300
      put(3, 8'h65);                                  // LDD @R5
      put(4, 8'h16); put(5, 8'h10); put(6, 8'h03);   // SET R6 0310
      put(7, 8'h76);                                  // STD @R6
      put(8, 8'hC6);                                  // POPD @R6
      put(9, 8'h85);                                  // POP @R5
      put(10, 8'h56);                                 // ST @R6
      put(11, 8'hE0);                                 // INR R0
      put(12, 8'h96);                                 // STP @R6
      put(13, 8'h17); put(14, 8'h20); put(15, 8'h03);// SET R7 0320
      put(16, 8'h26);                                 // LD R6
      put(17, 8'h77);                                 // STD @R7
      put(18, 8'h25);                                 // LD R5
      put(19, 8'h57);                                 // ST @R7
      put(20, 8'h00);                                 // RTN
      run_prog();
      chk("R5 std high byte", mem[16'h311], 8'hC3);
      chk("R4 stp after pop/inr", mem[16'h310], 8'hC4);
      chk("R4 R5 pointer lo", mem[16'h320], 8'h10);
      chk("R4 R5 pointer hi", mem[16'h321], 8'h03);
      chk("R4 pop pointer", mem[16'h322], 8'h01);
      chk("R10 ret pulses", ret_n, 1);
      chk("R10 quiet after ret", req_after, 0);

      // R9 R10: subroutine call, return, break
      begin_prog();
      put(0, 8'h1C); put(1, 8'h00); put(2, 8'h04);   // SET SP 0400
      put(3, 8'h0C); put(4, 8'h1B);                   // BS -> 0020
      put(5, 8'h21);                                  // LD R1
      put(6, 8'h13); put(7, 8'h00); put(8, 8'h05);   // SET R3 0500
      put(9, 8'h73);                                  // STD @R3
      put(10, 8'h0A);                                 // BK
      put(16'h20, 8'h11); put(16'h21, 8'h34); put(16'h22, 8'h12);
      put(16'h23, 8'h0B);                             // RS
      run_prog();
      chk("R9 pushed ret lo", mem[16'h400], 8'h05);
      chk("R9 pushed ret hi", mem[16'h401], 8'h00);
      chk("R3 R9 sub result lo", mem[16'h500], 8'h34);
      chk("R3 R9 sub result hi", mem[16'h501], 8'h12);
      chk("R10 brk pulses", brk_n, 1);
      chk("R10 no ret on brk", ret_n, 0);
      chk("R10 quiet after brk", req_after, 0);

      // R8: backward loop with DCR and BNZ
      begin_prog();
      put(0, 8'h11); put(1, 8'h05); put(2, 8'h00);   // SET R1 5
      put(3, 8'h12); put(4, 8'h00); put(5, 8'h00);   // SET R2 0
      put(6, 8'hE2);                                  // INR R2
      put(7, 8'hF1);                                  // DCR R1
      put(8, 8'h07); put(9, 8'hFC);                   // BNZ -4
      put(10, 8'h22);                                 // LD R2
      put(11, 8'h13); put(12, 8'h00); put(13, 8'h06);
      put(14, 8'h53);                                 // ST @R3
      put(15, 8'h00);
      run_prog();
      chk("R8 R3 loop count", mem[16'h600], 8'h05);

      // R6 R7 R8: arithmetic and conditions, corners then random
      for (int it = 0; it < 30; it++) begin
         logic [15:0] a, b, r;
         logic [3:0]  op, bo;
         bit c, tk;
         a = 16'($urandom); b = 16'($urandom);
         op = 4'hA + 4'($urandom % 3);
         if (op == 4'hC) op = 4'hD;
         bo = 4'h1 + 4'($urandom % 9);
         if (it == 0) begin a = 16'h1234; b = 16'h1234; op = 4'hD; bo = 4'h6; end
         if (it == 1) begin a = 16'h0000; b = 16'h0001; op = 4'hB; bo = 4'h8; end
         if (it == 2) begin a = 16'hFFFF; b = 16'h0001; op = 4'hA; bo = 4'h3; end
         if (it == 3) begin a = 16'h0001; b = 16'h0002; op = 4'hD; bo = 4'h2; end
         if (op == 4'hA) begin
            {c, r} = {1'b0, a} + {1'b0, b};
         end else begin
            r = a - b; c = (a >= b);
         end
         tk = br_take(bo, r, c);
         begin_prog();
         put(0, 8'h11); put(1, a[7:0]); put(2, a[15:8]);
         put(3, 8'h12); put(4, b[7:0]); put(5, b[15:8]);
         put(6, 8'h13); put(7, 8'h00); put(8, 8'h02);
         put(9, 8'h14); put(10, 8'h00); put(11, 8'h00);
         put(12, 8'h21);
         put(13, {op, 4'h2});
         put(14, {4'h0, bo}); put(15, 8'h01);
         put(16, 8'hE4);                              // skipped when taken
         put(17, (op == 4'hD) ? 8'h2D : 8'h20);
         put(18, 8'h73);
         put(19, 8'h24);
         put(20, 8'h53);
         put(21, 8'h00);
         mem[16'h200] = 8'hEE; mem[16'h201] = 8'hEE; mem[16'h202] = 8'hEE;
         run_prog();
         chk("R6 result lo", mem[16'h200], r[7:0]);
         chk("R6 result hi", mem[16'h201], r[15:8]);
         chk("R7 R8 branch outcome", mem[16'h202], tk ? 8'h00 : 8'h01);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 190000);
      errors++; checks++;
      $display("FAIL watchdog: global limit reached, actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule